// File: doc/BRIEF.md
# Two-Bank Page-Mode DRAM Controller

This block drives page-mode DRAM built as two banks that share one row strobe, one address bus and one write-enable, with a separate column strobe per bank. A processor hands it a command: direction, start bank, row, start column and burst length. The block multiplexes the row and column onto the address pins, issues the row strobe and one column strobe per data beat, collects read data, and paces write data through a valid/ready handshake. Each write beat is held in a register while it is written.

Strobe widths come at run time from a 2-bit timing code that selects one of four rows of a timing table. Two active-high disable inputs configure the controller. One selects whether the beats of a burst alternate between the two banks or stay on the start bank. The other selects whether the row is left open after an access, so that a later access to the same row skips the row phase. An interval counter, sized from the clock frequency, requests a strobe-column-before-row refresh every 13 µs. A refresh is serviced only between accesses.

Top module: `dram2b_ctrl`

## Requirements
- R1: The row strobe stays high for at least the precharge count before each falling edge. Timing code 00, 01, 10 and 11 gives 2, 3, 4 and 5 clocks.
- R2: Each low period of the row strobe lasts at least the minimum active count. Codes 00 to 11 give 3, 4, 5 and 6 clocks.
- R3: During an access, a column strobe stays low for exactly the read width on a read beat: 1, 2, 3 and 4 clocks for codes 00 to 11. On a write beat it stays low for the write width: 1, 1, 2 and 3 clocks.
- R4: With `cfg_ilv_off`=0, beat i of a burst strobes bank (start bank XOR i[0]) at column start+floor(i/2). Bit b of `dram_cas_n` is the strobe of bank b.
- R5: With `cfg_ilv_off`=1, every beat strobes the start bank, at column start+i.
- R6: With `cfg_page_off`=0, the row strobe stays low after an access. A following access to the same row produces no new falling edge of the row strobe. An access to a different row first raises the row strobe and then lowers it once.
- R7: With `cfg_page_off`=1, every access lowers the row strobe once. The row strobe is high again by the time `req_ready` returns.
- R8: The read beat is captured from `dram_dq_in` when its column strobe rises. It is presented on `rd_data`, with `rd_valid` high for one clock, on the clock after that rise. Beats come in burst order.
- R9: A write beat is taken when `wr_valid` and `wr_ready` are both high. Its column strobe falls only after it has been taken, with `dram_we_n` low and the beat on `dram_dq_out` with `dram_dq_oe` high. `req_ready` stays low from acceptance until the last beat has been strobed.
- R10: The block requests a refresh every CLK_KHZ*REF_NS/1e6 clocks, which is 1625 clocks by default. A refresh runs only between accesses. Both column strobes fall at least one clock before the row strobe falls. The row strobe then stays low for the minimum active count.
- R11: After reset, all strobes and `dram_we_n` are high, `req_ready` is high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_timing | input | 2 | Timing table code |
| cfg_ilv_off | input | 1 | 1 = no bank alternation within a burst |
| cfg_page_off | input | 1 | 1 = close the row after every access |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Command accepted when high with req_valid |
| req_write | input | 1 | 1 = write burst |
| req_bank | input | 1 | Start bank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Start column |
| req_len | input | LEN_W | Beats minus one |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat taken when high with wr_valid |
| wr_data | input | DATA_W | Write beat |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DATA_W | Read beat |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per bank, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to memory |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | DATA_W | Read data from memory |

## Verification
The properties assume that `cfg_timing` does not change while a burst is in flight, because strobe widths are judged against the code presented at the moment of each edge. They also assume that the memory returns read data while a column strobe is low. The stimulus changes the configuration only while the controller is idle and waiting for a command. A behavioural two-bank memory in the bench answers each column strobe from the row latched on the last row-strobe fall. Write beats are offered back to back and with gaps of several clocks, so the column-strobe wait is exercised in every timing row.

// File: rtl/dramctl_pkg.sv
package dramctl_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_RPRE,
        ST_RCAS,
        ST_RRAS
    } ctl_st_e;

    typedef struct packed {
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] wr;
    } tim_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/dramctl_timing.sv
module dramctl_timing
    import dramctl_pkg::*;
(
    input  logic [1:0] code,
    output tim_t       tim
);
    always_comb begin
        case (code)
            2'b00:   tim = '{pre: 3'd2, act: 3'd3, rd: 3'd1, wr: 3'd1};
            2'b01:   tim = '{pre: 3'd3, act: 3'd4, rd: 3'd2, wr: 3'd1};
            2'b10:   tim = '{pre: 3'd4, act: 3'd5, rd: 3'd3, wr: 3'd2};
            default: tim = '{pre: 3'd5, act: 3'd6, rd: 3'd4, wr: 3'd3};
        endcase
    end
endmodule

// File: rtl/dramctl_refresh.sv
module dramctl_refresh #(
    parameter int RELOAD = 1625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic pend
);
    localparam int CW = $clog2(RELOAD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } ref_t;

    ref_t d, q;

    always_comb begin
        d = q;
        if (grant) d.pend = 1'b0;
        if (q.cnt == '0) begin
            d.cnt  = CW'(RELOAD - 1);
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= CW'(RELOAD - 1);
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;
endmodule

// File: rtl/dramctl_beatmap.sv
module dramctl_beatmap #(
    parameter int COL_W = 10,
    parameter int LEN_W = 2
) (
    input  logic             ilv_en,
    input  logic             bank0,
    input  logic [COL_W-1:0] col0,
    input  logic [LEN_W-1:0] beat,
    output logic             bank,
    output logic [COL_W-1:0] col
);
    always_comb begin
        if (ilv_en) begin
            bank = bank0 ^ beat[0];
            col  = col0 + COL_W'(beat >> 1);
        end else begin
            bank = bank0;
            col  = col0 + COL_W'(beat);
        end
    end
endmodule

// File: rtl/dram2b_ctrl.sv
module dram2b_ctrl
    import dramctl_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ROW_W   = 10,
    parameter int COL_W   = 10,
    parameter int LEN_W   = 2,
    parameter int CLK_KHZ = 125000,
    parameter int REF_NS  = 13000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_timing,
    input  logic                     cfg_ilv_off,
    input  logic                     cfg_page_off,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    input  logic [LEN_W-1:0]         req_len,
    input  logic                     wr_valid,
    output logic                     wr_ready,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     dram_ras_n,
    output logic [1:0]               dram_cas_n,
    output logic                     dram_we_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int REF_RELOAD = (CLK_KHZ / 1000) * REF_NS / 1000;

    typedef struct packed {
        ctl_st_e           st;
        ctl_st_e           nxt;
        logic              ras_n;
        logic [1:0]        cas_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  ras_cnt;
        logic [CNT_W-1:0]  pre_cnt;
        logic [CNT_W-1:0]  cas_cnt;
        logic              open;
        logic [ROW_W-1:0]  open_row;
        logic              wr;
        logic              bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  beat;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rd_cap;
        logic              rd_vld;
    } ctl_t;

    ctl_t d, q;

    tim_t             tim;
    logic             ref_pend;
    logic             ref_grant;
    logic             bm_bank;
    logic [COL_W-1:0] bm_col;
    logic [CNT_W-1:0] cas_need;
    logic             beat_ok;

    dramctl_timing u_timing (
        .code (cfg_timing),
        .tim  (tim)
    );

    dramctl_refresh #(.RELOAD(REF_RELOAD)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (ref_grant),
        .pend  (ref_pend)
    );

    dramctl_beatmap #(.COL_W(COL_W), .LEN_W(LEN_W)) u_beatmap (
        .ilv_en (~cfg_ilv_off),
        .bank0  (q.bank),
        .col0   (q.col),
        .beat   (q.beat),
        .bank   (bm_bank),
        .col    (bm_col)
    );

    assign cas_need = q.wr ? tim.wr : tim.rd;
    assign beat_ok  = ~q.wr | wr_valid;

    always_comb begin
        d         = q;
        d.rd_cap  = 1'b0;
        d.rd_vld  = q.rd_cap;
        ref_grant = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_grant = 1'b1;
                    if (q.open) begin
                        d.st  = ST_CLOSE;
                        d.nxt = ST_RPRE;
                    end else begin
                        d.st = ST_RPRE;
                    end
                end else if (req_valid) begin
                    d.wr   = req_write;
                    d.bank = req_bank;
                    d.row  = req_row;
                    d.col  = req_col;
                    d.len  = req_len;
                    d.beat = '0;
                    d.we_n = ~req_write;
                    if (q.open && !cfg_page_off && (req_row == q.open_row)) begin
                        d.st = ST_ROW;
                    end else if (q.open) begin
                        d.st  = ST_CLOSE;
                        d.nxt = ST_PRE;
                    end else begin
                        d.st = ST_PRE;
                    end
                end
            end
            ST_CLOSE: begin
                if (q.ras_cnt >= tim.act) begin
                    d.ras_n = 1'b1;
                    d.open  = 1'b0;
                    d.st    = q.nxt;
                end
            end
            ST_PRE: begin
                if (q.pre_cnt >= tim.pre) begin
                    d.ras_n    = 1'b0;
                    d.addr     = ADDR_W'(q.row);
                    d.open     = 1'b1;
                    d.open_row = q.row;
                    d.st       = ST_ROW;
                end
            end
            ST_ROW: begin
                d.addr = ADDR_W'(bm_col);
                d.st   = ST_COL;
            end
            ST_COL: begin
                if (beat_ok) begin
                    d.cas_n          = 2'b11;
                    d.cas_n[bm_bank] = 1'b0;
                    d.cas_cnt        = 3'd1;
                    if (q.wr) d.wdata = wr_data;
                    d.st = ST_CAS;
                end
            end
            ST_CAS: begin
                if (q.cas_cnt >= cas_need) begin
                    d.cas_n = 2'b11;
                    if (!q.wr) begin
                        d.rdata  = dram_dq_in;
                        d.rd_cap = 1'b1;
                    end
                    if (q.beat == q.len) begin
                        d.we_n = 1'b1;
                        if (cfg_page_off) begin
                            d.st  = ST_CLOSE;
                            d.nxt = ST_IDLE;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.beat = q.beat + 1'b1;
                        d.st   = ST_ROW;
                    end
                end else begin
                    d.cas_cnt = sat_inc(q.cas_cnt);
                end
            end
            ST_RPRE: begin
                if (q.pre_cnt >= tim.pre) begin
                    d.cas_n = 2'b00;
                    d.st    = ST_RCAS;
                end
            end
            ST_RCAS: begin
                d.ras_n = 1'b0;
                d.st    = ST_RRAS;
            end
            ST_RRAS: begin
                if (q.ras_cnt >= tim.act) begin
                    d.ras_n = 1'b1;
                    d.cas_n = 2'b11;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        d.ras_cnt = d.ras_n ? '0 : (q.ras_n ? CNT_W'(1) : sat_inc(q.ras_cnt));
        d.pre_cnt = !d.ras_n ? '0 : (!q.ras_n ? CNT_W'(1) : sat_inc(q.pre_cnt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.nxt      <= ST_IDLE;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 2'b11;
            q.we_n     <= 1'b1;
            q.pre_cnt  <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE) && !ref_pend;
    assign wr_ready    = (q.st == ST_COL) && q.wr;
    assign rd_valid    = q.rd_vld;
    assign rd_data     = q.rdata;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_addr   = q.addr;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = ~q.we_n;
endmodule

// File: rtl/dram2b_ctrl_chk.sv
module dram2b_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_timing,
    input logic       ras_n,
    input logic [1:0] cas_n,
    input logic       we_n,
    input logic       rd_valid,
    input logic       req_ready,
    input logic       wr_ready
);
    logic [7:0] hi_cnt, lo_cnt, c0_cnt, c1_cnt;
    logic [7:0] t_pre, t_act, t_rd, t_wr;

    assign t_pre = 8'(cfg_timing) + 8'd2;
    assign t_act = 8'(cfg_timing) + 8'd3;
    assign t_rd  = 8'(cfg_timing) + 8'd1;
    assign t_wr  = (cfg_timing == 2'b00) ? 8'd1 : 8'(cfg_timing);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 8'hff;
            lo_cnt <= 8'd0;
            c0_cnt <= 8'd0;
            c1_cnt <= 8'd0;
        end else begin
            hi_cnt <= ras_n ? ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 8'd1) : 8'd0;
            lo_cnt <= !ras_n ? ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 8'd1) : 8'd0;
            c0_cnt <= !cas_n[0] ? ((c0_cnt == 8'hff) ? c0_cnt : c0_cnt + 8'd1) : 8'd0;
            c1_cnt <= !cas_n[1] ? ((c1_cnt == 8'hff) ? c1_cnt : c1_cnt + 8'd1) : 8'd0;
        end
    end

    // R1
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt >= t_pre);

    // R2
    ras_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> lo_cnt >= t_act);

    // R3
    cas0_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_n[0]) && !ras_n) |-> c0_cnt == ($past(we_n) ? t_rd : t_wr));

    // R3
    cas1_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_n[1]) && !ras_n) |-> c1_cnt == ($past(we_n) ? t_rd : t_wr));

    // R4
    single_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !$onehot0(~cas_n)) |-> $past(cas_n) == 2'b00);

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cas_n, 2) != 2'b11 && $past(cas_n) == 2'b11 && $past(we_n, 2)));

    // R9
    wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!we_n && cas_n == 2'b11 && !req_ready));

    // R10
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n != 2'b11) |-> (cas_n == 2'b00 && $past(cas_n) == 2'b00));

    // R11
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cas_n == 2'b11);
endmodule

bind dram2b_ctrl dram2b_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_timing (cfg_timing),
    .ras_n      (dram_ras_n),
    .cas_n      (dram_cas_n),
    .we_n       (dram_we_n),
    .rd_valid   (rd_valid),
    .req_ready  (req_ready),
    .wr_ready   (wr_ready)
);

// File: tb/tb_dram2b_ctrl.sv
`timescale 1ns/1ps
module tb_dram2b_ctrl;
    localparam int RELOAD = (125000 / 1000) * 13000 / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_timing = 2'b00;
    logic        cfg_ilv_off = 1'b0;
    logic        cfg_page_off = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_bank = 1'b0;
    logic [9:0]  req_row = '0;
    logic [9:0]  req_col = '0;
    logic [1:0]  req_len = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_data = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ras_n;
    logic [1:0]  cas_n;
    logic        we_n;
    logic [9:0]  addr;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] dq_in = '0;

    always #4 clk = ~clk;

    dram2b_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .cfg_ilv_off(cfg_ilv_off), .cfg_page_off(cfg_page_off),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int t_pre(input int c);  return c + 2; endfunction
    function automatic int t_act(input int c);  return c + 3; endfunction
    function automatic int t_rd(input int c);   return c + 1; endfunction
    function automatic int t_wr(input int c);   return (c == 0) ? 1 : c; endfunction

    // memory model and observers
    logic [15:0] mem [0:1][0:3][0:15];
    int  ev_bank [0:1023];
    int  ev_col  [0:1023];
    logic [15:0] rdbuf [0:1023];
    int  nev = 0, nrd = 0, nfall = 0, nrise = 0, nref = 0, hs = 0, wcas = 0;
    int  cyc = 0, last_ref = 0, last_rd_rise = -10;
    int  hi_run = 100, lo_run = 0;
    int  cas_run [0:1];
    logic [1:0] row_lat = '0;
    logic prev_ras = 1'b1, prev_we = 1'b1;
    logic [1:0] prev_cas = 2'b11;

    initial begin
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 16; c++) mem[b][r][c] = '0;
        cas_run[0] = 0;
        cas_run[1] = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_ras && !ras_n) begin
                check(hi_run >= t_pre(cfg_timing), "R1", hi_run, t_pre(cfg_timing));
                if (cas_n == 2'b11) begin
                    row_lat = addr[1:0];
                    nfall++;
                end else begin
                    check(prev_cas == 2'b00 && cas_n == 2'b00, "R10", int'(prev_cas), 0);
                    if (nref > 0)
                        check((cyc - last_ref) >= RELOAD - 80 && (cyc - last_ref) <= RELOAD + 80,
                              "R10", cyc - last_ref, RELOAD);
                    last_ref = cyc;
                    nref++;
                end
                lo_run = 1;
            end else if (!prev_ras && ras_n) begin
                check(lo_run >= t_act(cfg_timing), "R2", lo_run, t_act(cfg_timing));
                nrise++;
                hi_run = 1;
            end else if (ras_n) begin
                hi_run++;
            end else begin
                lo_run++;
            end
            for (int b = 0; b < 2; b++) begin
                if (prev_cas[b] && !cas_n[b] && !ras_n) begin
                    ev_bank[nev] = b;
                    ev_col[nev]  = int'(addr[3:0]);
                    nev++;
                    if (!we_n) begin
                        mem[b][row_lat][addr[3:0]] = dq_out;
                        wcas++;
                        check(hs >= wcas, "R9", hs, wcas);
                        check(dq_oe == 1'b1, "R9", int'(dq_oe), 1);
                    end else begin
                        dq_in = mem[b][row_lat][addr[3:0]];
                    end
                    cas_run[b] = 1;
                end else if (!prev_cas[b] && cas_n[b] && !ras_n) begin
                    check(cas_run[b] == (prev_we ? t_rd(cfg_timing) : t_wr(cfg_timing)), "R3",
                          cas_run[b], prev_we ? t_rd(cfg_timing) : t_wr(cfg_timing));
                    if (prev_we) last_rd_rise = cyc;
                end else if (!cas_n[b]) begin
                    cas_run[b]++;
                end
            end
            if (rd_valid) begin
                check(cyc - last_rd_rise == 1, "R8", cyc - last_rd_rise, 1);
                rdbuf[nrd] = rd_data;
                nrd++;
            end
            if (wr_valid && wr_ready) hs++;
            prev_ras = ras_n;
            prev_cas = cas_n;
            prev_we  = we_n;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_refresh();
        int r0;
        r0 = nref;
        while (nref == r0) tick();
        repeat (12) tick();
    endtask

    task automatic do_acc(input bit wr, input bit bk, input int row, input int col,
                          input int len, input int gap, input int base,
                          input int exp_falls, input bit chk_data);
        int f0, e0, r0, early;
        f0 = nfall; e0 = nev; r0 = nrd; early = 0;
        req_valid = 1'b1; req_write = wr; req_bank = bk;
        req_row = 10'(row); req_col = 10'(col); req_len = 2'(len);
        while (!req_ready) tick();
        tick();
        req_valid = 1'b0;
        if (wr) begin
            for (int i = 0; i <= len; i++) begin
                repeat (gap) tick();
                wr_valid = 1'b1;
                wr_data = 16'(base + i);
                while (!wr_ready) begin
                    if (req_ready) early++;
                    tick();
                end
                tick();
                wr_valid = 1'b0;
            end
        end
        while (nev < e0 + len + 1 || cas_n != 2'b11) begin
            if (req_ready) early++;
            tick();
        end
        // R9 command handshake held off for the whole burst
        check(early == 0, "R9", early, 0);
        while (!req_ready) tick();
        repeat (3) tick();
        // R6 / R7 row strobe fall count
        check(nfall - f0 == exp_falls, cfg_page_off ? "R7" : "R6", nfall - f0, exp_falls);
        // R6 / R7 row left open or closed
        check(ras_n == cfg_page_off || nref > 0 && ras_n == 1'b1 && cfg_page_off,
              cfg_page_off ? "R7" : "R6", int'(ras_n), int'(cfg_page_off));
        for (int i = 0; i <= len; i++) begin
            int eb, ec;
            if (!cfg_ilv_off) begin
                eb = int'(bk) ^ (i & 1);
                ec = col + i / 2;
                check(ev_bank[e0 + i] == eb && ev_col[e0 + i] == ec, "R4",
                      ev_bank[e0 + i] * 100 + ev_col[e0 + i], eb * 100 + ec);
            end else begin
                eb = int'(bk);
                ec = col + i;
                check(ev_bank[e0 + i] == eb && ev_col[e0 + i] == ec, "R5",
                      ev_bank[e0 + i] * 100 + ev_col[e0 + i], eb * 100 + ec);
            end
        end
        if (!wr) begin
            check(nrd - r0 == len + 1, "R8", nrd - r0, len + 1);
            if (chk_data)
                for (int i = 0; i <= len; i++)
                    check(rdbuf[r0 + i] == 16'(base + i), "R8",
                          int'(rdbuf[r0 + i]), base + i);
        end
    endtask

    initial begin
        repeat (3) tick();
        // R11 reset state
        check(ras_n == 1'b1 && cas_n == 2'b11 && we_n == 1'b1, "R11",
              int'({ras_n, cas_n, we_n}), 15);
        check(req_ready == 1'b1 && rd_valid == 1'b0, "R11", int'({req_ready, rd_valid}), 2);
        rst_n = 1'b1;
        tick();
        check(ras_n == 1'b1 && cas_n == 2'b11 && req_ready == 1'b1, "R11",
              int'({ras_n, cas_n, req_ready}), 15);
        for (int k = 0; k < 16; k++) begin
            int code, bk, r0, r1, c, pg, rises0;
            code = k >> 2;
            cfg_timing   = 2'(code);
            cfg_ilv_off  = k[1];
            cfg_page_off = k[0];
            pg = k[0];
            bk = (k >> 1) & 1;
            r0 = (k & 2);
            r1 = r0 + 1;
            c  = k & 3;
            wait_refresh();
            do_acc(1'b1, bk[0], r0, c, 3, 0, k * 256 + 16'hA0, 1, 1'b0);
            do_acc(1'b0, bk[0], r0, c, 3, 0, k * 256 + 16'hA0, pg, 1'b1);
            rises0 = nrise;
            do_acc(1'b0, ~bk[0], r1, c, 1, 0, 0, 1, 1'b0);
            // R6 different row closes the old row first
            check(nrise - rises0 >= 1, "R6", nrise - rises0, 1);
            do_acc(1'b1, bk[0], r1, c + 4, 3, 3, k * 256 + 16'hD0, pg, 1'b0);
            do_acc(1'b0, bk[0], r1, c + 4, 3, 0, k * 256 + 16'hD0, pg, 1'b1);
        end
        repeat (20) tick();
        // R10 refreshes kept coming during the run
        check(nref >= 16, "R10", nref, 16);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule